// File: doc/BRIEF.md
# Translation Table Probe Walker

This block answers one question about a logical address: what would a translation table walk find for it, and which access checks would fail on the way? A start pulse launches a probe with a logical address, a three-bit function code, a requested search depth, an access level and a read or write probe mode. The walker first asks the translation cache about the address. It then fetches descriptors level by level from memory and folds the checks made at every level it visits into one sticky status word. The probe is read-only. It never writes table entries or their used and modified bits, and it never loads the cache.

Descriptor fetches go out on a valid/ready request channel. Once `mem_req_valid` is raised, the request and its address stay unchanged until a cycle in which `mem_req_ready` is high. At most one fetch is outstanding at a time. The memory answers each accepted request with exactly one `mem_rsp_valid` beat, which the walker always accepts. That beat may carry an error flag. The cache lookup port is plain and combinational: the walker drives the address and function code of the probe, and the cache returns hit, error and modified bits.

When the probe ends, `done` pulses for one cycle. The status flags and the byte address of the last descriptor that was read completely are valid on that pulse. They stay unchanged until the next start.

Top module: `xpw_walker`

## Requirements
- R1: `done` is high for exactly one cycle per probe. `st_flags` and `st_last_addr` are valid on that cycle and hold their values until the next `start`. After reset, both are zero and `done` is low.
- R2: A raised `mem_req_valid` keeps its value, and `mem_req_addr` stays stable, until `mem_req_ready` is seen high. Request addresses are word aligned. A table entry sits at base + index*4 in a short table and at base + index*8 in a long table. The second word of a long entry is fetched at entry + 4.
- R3: Descriptor word 0 is laid out as follows: [1:0] type (00 invalid, 01 page, 10 pointer to a short table, 11 pointer to a long table), [2] write protect, [3] modified, [AW-1:4] upper bits of the next table base. Word 1 of a long entry is laid out as follows: [7:0] limit on the next table's index, [8] supervisor only, [11:9] write level, [14:12] read level. The root type uses the same codes.
- R4: The level-n index is the n-th IDX_W-bit field of the address, counted down from its top bit. The walk stops at a page entry, at an invalid entry, on a limit failure, on a fetch error, or after the requested level when that level still holds a pointer. `st_flags[1]` (invalid) is set whenever no page entry was reached.
- R5: If an index is greater than the limit in the long entry that points to its table, `st_flags[5]` and the invalid flag are set. No fetch is made for that index.
- R6: `st_flags[4]` is set when a visited long entry is supervisor only and bit 2 of the function code is 0. This check does not stop the walk.
- R7: A level field denies access when `probe_alvl` is numerically greater than it. `st_flags[3]` is set on a read-level denial in either mode. In write mode (`probe_wr`=1) it is also set on a write-level denial.
- R8: `st_flags[2]` is set when any visited entry has its write-protect bit set, or when any write-level field denies access, in either mode.
- R9: A fetch that returns an error sets `st_flags[6]` and the invalid flag and ends the walk. At level 0, `st_flags[6]` is set when the cache hits with its error bit set. At any other level, the cache error bit is ignored.
- R10: `st_flags[0]` takes the cache modified bit on a cache hit. Otherwise it takes the modified bit of the page entry that was reached, and it is 0 when no page entry was reached.
- R11: `st_last_addr` is the entry address of the last descriptor whose words all arrived without error. It is 0 when nothing was read, including when the root type is page or invalid.
- R12: A requested level of 0 is a cache-only probe with no memory fetch. In that case the invalid flag is the inverse of the cache hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Launch a probe (taken while idle) |
| probe_va | input | AW | Logical address under test |
| probe_fc | input | 3 | Function code; bit 2 marks supervisor |
| probe_level | input | LVL_W | Requested search depth, 0 = cache only |
| probe_wr | input | 1 | 1 = write probe, 0 = read probe |
| probe_alvl | input | 3 | Access level compared against level fields |
| root_type | input | 2 | Type code of the root pointer |
| root_addr | input | AW | Base of the first-level table |
| cache_va | output | AW | Address presented to the cache |
| cache_fc | output | 3 | Function code presented to the cache |
| cache_hit | input | 1 | Cache holds the address |
| cache_berr | input | 1 | Error bit of the hit entry |
| cache_mod | input | 1 | Modified bit of the hit entry |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | AW | Byte address of the fetched word |
| mem_rsp_valid | input | 1 | Fetched word is present |
| mem_rsp_data | input | AW | Fetched word |
| mem_rsp_err | input | 1 | Fetch ended with an error |
| done | output | 1 | One-cycle end-of-probe pulse |
| st_flags | output | 7 | [6] error, [5] limit, [4] supervisor, [3] access level, [2] write protect, [1] invalid, [0] modified |
| st_last_addr | output | AW | Last fully read descriptor address |

## Verification
The bench targets three cases. First, an error on the second word of a long entry: a design that latches the address after the first word would return a non-zero last address there. Second, a limit failure: a design that fetches before comparing would show an extra fetch in the bench's per-probe count. Third, a read-probe write-level denial: a design that treats both modes alike would raise the access flag where only write protect belongs. Other targets are cache-only probes and root pointers of page or invalid type (no fetch, last address 0), a cache hit that overrides the page modified bit, and a cache error bit that must be ignored above level 0. Random-looking back-pressure on the request channel catches any request that drops or moves its address while it stalls.

// File: rtl/xpw_pkg.sv
package xpw_pkg;
  localparam logic [1:0] DT_INVALID = 2'b00;
  localparam logic [1:0] DT_PAGE    = 2'b01;
  localparam logic [1:0] DT_SHORT   = 2'b10;
  localparam logic [1:0] DT_LONG    = 2'b11;

  localparam int W0_WP_BIT  = 2;
  localparam int W0_MOD_BIT = 3;
  localparam int W0_ADR_LSB = 4;

  localparam int LIM_W   = 8;
  localparam int SUP_BIT = 8;
  localparam int WAL_LSB = 9;
  localparam int RAL_LSB = 12;
  localparam int AL_W    = 3;
  localparam int EXT_W   = RAL_LSB + AL_W;

  localparam int FL_BERR  = 6;
  localparam int FL_LIMIT = 5;
  localparam int FL_SUPER = 4;
  localparam int FL_ACC   = 3;
  localparam int FL_WP    = 2;
  localparam int FL_INV   = 1;
  localparam int FL_MOD   = 0;
  localparam int FL_W     = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_CACHE, S_INDEX, S_REQ, S_RSP, S_EVAL, S_FIN
  } walk_state_t;
endpackage

// File: rtl/xpw_index.sv
module xpw_index #(
  parameter int AW    = 32,
  parameter int IDX_W = 4,
  parameter int LVL_W = 2
) (
  input  logic [AW-1:0]    va,
  input  logic [LVL_W-1:0] level,
  input  logic [AW-1:0]    base,
  input  logic             long_tbl,
  output logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    ent_addr
);
  logic [AW-1:0] shifted;
  logic [AW-1:0] ix;

  always_comb begin
    shifted  = va << (IDX_W * (int'(level) - 1));
    idx      = shifted[AW-1 -: IDX_W];
    ix       = AW'(idx);
    ent_addr = base + (long_tbl ? (ix << 3) : (ix << 2));
  end
endmodule

// File: rtl/xpw_rights.sv
module xpw_rights
  import xpw_pkg::*;
(
  input  logic [EXT_W-1:0] ext,
  input  logic             fc_super,
  input  logic [AL_W-1:0]  alvl,
  input  logic             wr_mode,
  output logic [LIM_W-1:0] limit,
  output logic             sup_viol,
  output logic             acc_deny,
  output logic             wp_deny
);
  logic [AL_W-1:0] wal;
  logic [AL_W-1:0] ral;
  logic            wal_no;
  logic            ral_no;

  always_comb begin
    limit    = ext[LIM_W-1:0];
    wal      = ext[WAL_LSB +: AL_W];
    ral      = ext[RAL_LSB +: AL_W];
    wal_no   = alvl > wal;
    ral_no   = alvl > ral;
    sup_viol = ext[SUP_BIT] && !fc_super;
    acc_deny = ral_no || (wr_mode && wal_no);
    wp_deny  = wal_no;
  end
endmodule

// File: rtl/xpw_walker.sv
module xpw_walker
  import xpw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 4,
  parameter int NLVL  = 3,
  parameter int LVL_W = $clog2(NLVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    probe_va,
  input  logic [2:0]       probe_fc,
  input  logic [LVL_W-1:0] probe_level,
  input  logic             probe_wr,
  input  logic [2:0]       probe_alvl,
  input  logic [1:0]       root_type,
  input  logic [AW-1:0]    root_addr,
  output logic [AW-1:0]    cache_va,
  output logic [2:0]       cache_fc,
  input  logic             cache_hit,
  input  logic             cache_berr,
  input  logic             cache_mod,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [AW-1:0]    mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [AW-1:0]    mem_rsp_data,
  input  logic             mem_rsp_err,
  output logic             done,
  output logic [FL_W-1:0]  st_flags,
  output logic [AW-1:0]    st_last_addr
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NLVL);
  localparam logic [AW-1:0]    BEAT_OFS = AW'(4);

  walk_state_t      state;
  logic [AW-1:0]    va_q;
  logic [2:0]       fc_q;
  logic [LVL_W-1:0] lvl_q;
  logic [LVL_W-1:0] cur;
  logic             wr_q;
  logic [AL_W-1:0]  alvl_q;
  logic             hit_q;
  logic [AW-1:0]    base_q;
  logic             long_q;
  logic             lim_v;
  logic [LIM_W-1:0] lim_q;
  logic [AW-1:0]    ent_q;
  logic             beat;
  logic [AW-1:0]    w0_q;
  logic [EXT_W-1:0] w1_q;
  logic [FL_W-1:0]  flags;
  logic [AW-1:0]    last_q;
  logic             done_q;

  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    ent_addr;
  logic [LIM_W-1:0] ent_lim;
  logic             sup_viol;
  logic             acc_deny;
  logic             wp_deny;
  logic             over_lim;

  xpw_index #(.AW(AW), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_index (
    .va       (va_q),
    .level    (cur),
    .base     (base_q),
    .long_tbl (long_q),
    .idx      (idx),
    .ent_addr (ent_addr)
  );

  xpw_rights u_rights (
    .ext      (w1_q),
    .fc_super (fc_q[2]),
    .alvl     (alvl_q),
    .wr_mode  (wr_q),
    .limit    (ent_lim),
    .sup_viol (sup_viol),
    .acc_deny (acc_deny),
    .wp_deny  (wp_deny)
  );

  assign over_lim = lim_v && (LIM_W'(idx) > lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      va_q   <= '0;
      fc_q   <= '0;
      lvl_q  <= '0;
      cur    <= '0;
      wr_q   <= 1'b0;
      alvl_q <= '0;
      hit_q  <= 1'b0;
      base_q <= '0;
      long_q <= 1'b0;
      lim_v  <= 1'b0;
      lim_q  <= '0;
      ent_q  <= '0;
      beat   <= 1'b0;
      w0_q   <= '0;
      w1_q   <= '0;
      flags  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            va_q   <= probe_va;
            fc_q   <= probe_fc;
            lvl_q  <= (probe_level > MAX_LVL) ? MAX_LVL : probe_level;
            wr_q   <= probe_wr;
            alvl_q <= probe_alvl;
            flags  <= '0;
            last_q <= '0;
            state  <= S_CACHE;
          end
        end
        S_CACHE: begin
          hit_q <= cache_hit;
          flags[FL_MOD] <= cache_hit && cache_mod;
          if (lvl_q == '0) begin
            flags[FL_BERR] <= cache_hit && cache_berr;
            flags[FL_INV]  <= !cache_hit;
            state <= S_FIN;
          end else begin
            case (root_type)
              DT_INVALID: begin
                flags[FL_INV] <= 1'b1;
                state <= S_FIN;
              end
              DT_PAGE: state <= S_FIN;
              default: begin
                base_q <= root_addr;
                long_q <= root_type[0];
                lim_v  <= 1'b0;
                cur    <= LVL_W'(1);
                state  <= S_INDEX;
              end
            endcase
          end
        end
        S_INDEX: begin
          if (over_lim) begin
            flags[FL_LIMIT] <= 1'b1;
            flags[FL_INV]   <= 1'b1;
            state <= S_FIN;
          end else begin
            ent_q <= ent_addr;
            beat  <= 1'b0;
            state <= S_REQ;
          end
        end
        S_REQ: begin
          if (mem_req_ready) state <= S_RSP;
        end
        S_RSP: begin
          if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              flags[FL_BERR] <= 1'b1;
              flags[FL_INV]  <= 1'b1;
              state <= S_FIN;
            end else if (!beat) begin
              w0_q <= mem_rsp_data;
              if (long_q) begin
                beat  <= 1'b1;
                state <= S_REQ;
              end else begin
                w1_q  <= '0;
                state <= S_EVAL;
              end
            end else begin
              w1_q  <= mem_rsp_data[EXT_W-1:0];
              state <= S_EVAL;
            end
          end
        end
        S_EVAL: begin
          last_q <= ent_q;
          if (w0_q[W0_WP_BIT] || (long_q && wp_deny)) flags[FL_WP] <= 1'b1;
          if (long_q && sup_viol) flags[FL_SUPER] <= 1'b1;
          if (long_q && acc_deny) flags[FL_ACC] <= 1'b1;
          case (w0_q[1:0])
            DT_INVALID: begin
              flags[FL_INV] <= 1'b1;
              state <= S_FIN;
            end
            DT_PAGE: begin
              if (!hit_q) flags[FL_MOD] <= w0_q[W0_MOD_BIT];
              state <= S_FIN;
            end
            default: begin
              if (cur == lvl_q) begin
                flags[FL_INV] <= 1'b1;
                state <= S_FIN;
              end else begin
                base_q <= {w0_q[AW-1:W0_ADR_LSB], {W0_ADR_LSB{1'b0}}};
                long_q <= w0_q[0];
                lim_v  <= long_q;
                lim_q  <= ent_lim;
                cur    <= cur + 1'b1;
                state  <= S_INDEX;
              end
            end
          endcase
        end
        S_FIN: begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cache_va      = va_q;
  assign cache_fc      = fc_q;
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = beat ? (ent_q + BEAT_OFS) : ent_q;
  assign done          = done_q;
  assign st_flags      = flags;
  assign st_last_addr  = last_q;
endmodule

// File: rtl/xpw_walker_chk.sv
module xpw_walker_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          done,
  input logic [6:0]    st_flags,
  input logic [AW-1:0] st_last_addr
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1

  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(st_flags) && $stable(st_last_addr))); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R2

  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R2

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req_valid); // R4

  AST_LIMIT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_flags[5]) |-> st_flags[1]); // R5
endmodule

bind xpw_walker xpw_walker_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .st_flags      (st_flags),
  .st_last_addr  (st_last_addr)
);

// File: tb/tb_xpw_walker.sv
module tb_xpw_walker;
  localparam int AW = 32;
  localparam int NV = 22;

  typedef struct packed {
    logic [31:0] va;
    logic [2:0]  fc;
    logic [1:0]  lvl;
    logic        wr;
    logic [2:0]  alvl;
    logic [1:0]  rtype;
    logic [31:0] raddr;
    logic        chit;
    logic        cberr;
    logic        cmod;
    logic [6:0]  eflags;
    logic [31:0] elast;
    logic [3:0]  efetch;
    logic [3:0]  rq;
  } vec_t;

  // flags: [6] err [5] limit [4] super [3] acc [2] wp [1] inv [0] mod
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h00, 32'h200, 4'd3, 4'd2},  // R2 R3 long then short
    '{32'h0100_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h01, 32'h204, 4'd3, 4'd10}, // R10 page mod
    '{32'h0200_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h01, 32'h400, 4'd4, 4'd4},  // R4 three levels
    '{32'h0200_0000, 3'd5, 2'd2, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h02, 32'h208, 4'd3, 4'd4},  // R4 stop at level
    '{32'h2000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h02, 32'h110, 4'd2, 4'd4},  // R4 invalid entry
    '{32'h3000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h05, 32'h118, 4'd2, 4'd8},  // R8 wp bit
    '{32'h4000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h42, 32'h000, 4'd2, 4'd11}, // R11 err on 2nd word
    '{32'h0300_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h42, 32'h100, 4'd3, 4'd9},  // R9 fetch error
    '{32'h1100_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h04, 32'h308, 4'd4, 4'd8},  // R8 long page wp
    '{32'h1000_0000, 3'd1, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h10, 32'h300, 4'd4, 4'd6},  // R6 user fc
    '{32'h1300_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h22, 32'h108, 4'd2, 4'd5},  // R5 limit
    '{32'h1000_0000, 3'd5, 2'd3, 1'b0, 3'd2, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h04, 32'h300, 4'd4, 4'd7},  // R7 read probe wal
    '{32'h1000_0000, 3'd5, 2'd3, 1'b1, 3'd2, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h0C, 32'h300, 4'd4, 4'd7},  // R7 write probe wal
    '{32'h1000_0000, 3'd5, 2'd3, 1'b0, 3'd4, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h0C, 32'h300, 4'd4, 4'd7},  // R7 read probe ral
    '{32'h0000_0000, 3'd5, 2'd0, 1'b0, 3'd0, 2'b11, 32'h100, 1'b1, 1'b1, 1'b1, 7'h41, 32'h000, 4'd0, 4'd12}, // R12 cache err
    '{32'h0000_0000, 3'd5, 2'd0, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h02, 32'h000, 4'd0, 4'd12}, // R12 miss
    '{32'h0000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b01, 32'h100, 1'b0, 1'b0, 1'b0, 7'h00, 32'h000, 4'd0, 4'd11}, // R11 root page
    '{32'h0000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b00, 32'h100, 1'b0, 1'b0, 1'b0, 7'h02, 32'h000, 4'd0, 4'd3},  // R3 root invalid
    '{32'h0100_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b1, 1'b1, 1'b0, 7'h00, 32'h204, 4'd3, 4'd9},  // R9 R10 hit overrides
    '{32'h0000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b10, 32'h200, 1'b0, 1'b0, 1'b0, 7'h00, 32'h200, 4'd1, 4'd3},  // R3 short root
    '{32'h0000_0000, 3'd5, 2'd1, 1'b0, 3'd0, 2'b11, 32'h100, 1'b0, 1'b0, 1'b0, 7'h02, 32'h100, 4'd2, 4'd4},  // R4 level 1
    '{32'h0000_0000, 3'd5, 2'd3, 1'b0, 3'd0, 2'b11, 32'h100, 1'b1, 1'b0, 1'b1, 7'h01, 32'h200, 4'd3, 4'd10}  // R10 cache mod
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] probe_va = '0;
  logic [2:0]    probe_fc = '0;
  logic [1:0]    probe_level = '0;
  logic          probe_wr = 1'b0;
  logic [2:0]    probe_alvl = '0;
  logic [1:0]    root_type = '0;
  logic [AW-1:0] root_addr = '0;
  logic [AW-1:0] cache_va;
  logic [2:0]    cache_fc;
  logic          cache_hit = 1'b0;
  logic          cache_berr = 1'b0;
  logic          cache_mod = 1'b0;
  logic          mem_req_valid;
  logic          mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [AW-1:0] mem_rsp_data = '0;
  logic          mem_rsp_err = 1'b0;
  logic          done;
  logic [6:0]    st_flags;
  logic [AW-1:0] st_last_addr;

  int tests = 0;
  int fails = 0;
  int fetches = 0;
  int hold_errs = 0;
  int stall_cnt = 0;
  logic          hs = 1'b0;
  logic [AW-1:0] hs_addr = '0;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [31:0]   tmem [0:1023];

  always #5 clk = ~clk;

  xpw_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .probe_va(probe_va),
    .probe_fc(probe_fc), .probe_level(probe_level), .probe_wr(probe_wr),
    .probe_alvl(probe_alvl), .root_type(root_type), .root_addr(root_addr),
    .cache_va(cache_va), .cache_fc(cache_fc), .cache_hit(cache_hit),
    .cache_berr(cache_berr), .cache_mod(cache_mod),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .done(done), .st_flags(st_flags), .st_last_addr(st_last_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural table memory with back-pressure and injected errors
  always @(negedge clk) begin
    if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_errs++;
    if (hs) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = tmem[hs_addr[11:2]];
      mem_rsp_err   = (hs_addr == 32'h124) || (hs_addr == 32'h20C);
      hs = 1'b0;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_err   = 1'b0;
    end
    stall_cnt++;
    mem_req_ready = (stall_cnt % 3) != 2;
    prev_stall = mem_req_valid && !mem_req_ready;
    prev_addr  = mem_req_addr;
    if (mem_req_valid && mem_req_ready) begin
      hs = 1'b1;
      hs_addr = mem_req_addr;
      fetches++;
    end
  end

  task automatic run_probe(input vec_t v, output bit got);
    got = 1'b0;
    @(negedge clk);
    probe_va = v.va; probe_fc = v.fc; probe_level = v.lvl; probe_wr = v.wr;
    probe_alvl = v.alvl; root_type = v.rtype; root_addr = v.raddr;
    cache_hit = v.chit; cache_berr = v.cberr; cache_mod = v.cmod;
    fetches = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        got = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit got;
    for (int i = 0; i < 1024; i++) tmem[i] = 32'h0;
    tmem[32'h100 >> 2] = 32'h0000_0202; tmem[32'h104 >> 2] = 32'h0000_7EFF;
    tmem[32'h108 >> 2] = 32'h0000_0303; tmem[32'h10C >> 2] = 32'h0000_3302;
    tmem[32'h118 >> 2] = 32'h0000_500D; tmem[32'h11C >> 2] = 32'h0000_7EFF;
    tmem[32'h120 >> 2] = 32'h0000_0202; tmem[32'h124 >> 2] = 32'h0000_7EFF;
    tmem[32'h200 >> 2] = 32'h0000_6001; tmem[32'h204 >> 2] = 32'h0000_6009;
    tmem[32'h208 >> 2] = 32'h0000_0402;
    tmem[32'h300 >> 2] = 32'h0000_7001; tmem[32'h304 >> 2] = 32'h0000_7EFF;
    tmem[32'h308 >> 2] = 32'h0000_7005; tmem[32'h30C >> 2] = 32'h0000_7EFF;
    tmem[32'h400 >> 2] = 32'h0000_8009;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done == 1'b0, "R1 reset done", 32'(done), 32'h0);
    chk(mem_req_valid == 1'b0, "R2 reset req", 32'(mem_req_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_flags == 7'h0, "R1 reset flags", 32'(st_flags), 32'h0);
    chk(st_last_addr == '0, "R1 reset addr", st_last_addr, 32'h0);

    for (int k = 0; k < NV; k++) begin
      run_probe(VECS[k], got);
      chk(got, $sformatf("R%0d vec %0d done", VECS[k].rq, k), 32'(got), 32'h1);
      chk(st_flags == VECS[k].eflags, $sformatf("R%0d vec %0d flags", VECS[k].rq, k),
          32'(st_flags), 32'(VECS[k].eflags));
      chk(st_last_addr == VECS[k].elast, $sformatf("R%0d vec %0d last", VECS[k].rq, k),
          st_last_addr, VECS[k].elast);
      chk(fetches == int'(VECS[k].efetch), $sformatf("R%0d vec %0d fetches", VECS[k].rq, k),
          32'(fetches), 32'(VECS[k].efetch));
    end

    // R1 pulse width and status hold after done
    run_probe(VECS[8], got);
    @(negedge clk);
    chk(done == 1'b0, "R1 done one cycle", 32'(done), 32'h0);
    probe_va = 32'hFFFF_FFFF; cache_hit = 1'b1; cache_mod = 1'b1;
    repeat (5) @(negedge clk);
    chk(st_flags == 7'h04, "R1 flags held", 32'(st_flags), 32'h04);
    chk(st_last_addr == 32'h308, "R1 addr held", st_last_addr, 32'h308);

    // R2 stalled requests never dropped or moved
    chk(hold_errs == 0, "R2 request hold", 32'(hold_errs), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule